// File: doc/BRIEF.md
# High-Speed Transmit Slew-Rate Calibration Sequencer

This block calibrates the transmit edge rate of one high-speed serial port. A single start pulse makes it switch on the port's ring oscillator, wait a fixed settling time, and then drive an on-chip frequency meter over a simple register master port. It enables the meter's free-running clock, loads a measurement window of 1024 cycles with the port's channel number, and starts detection. It then polls the meter's valid flag at a fixed interval until a result appears or a timeout runs out. After reading the count, it stops the meter and then its free-running clock.

The count stands for one oscillator period. A multi-cycle restoring divider turns it into a 3-bit slew-rate code. The block divides the constant 745472 (1024 × 26 × 28) by the count, then divides that quotient by 1000 with rounding to nearest. A zero count falls back to code 4, and results above 7 saturate at 7. The code is applied to the slew output while the oscillator is still on. The oscillator is switched off in the following cycle, and a one-cycle done pulse marks the end.

Top module: `srcal_seq`

## Requirements
- R1: A start pulse while idle raises `osc_en` on the next clock edge, and no bus request is made for at least SETTLE_US × CYC_PER_US cycles after that.
- R2: The first bus access is a write of 0x100 (free-run clock enable, bit 8) to the monitor register at address 0x10.
- R3: Next come two writes to the configuration register at address 0x00. Each carries the window length 1024 in bits 23:0 and the channel (`port_sel` captured at start) in bits 27:26. Bit 24 (detect enable) is clear in the first write and set in the second.
- R4: The monitor register is then read. If bit 0 (valid) is clear, it is read again after at least POLL_US × CYC_PER_US cycles. Once bit 0 is set, the next access reads the count register at address 0x0C.
- R5: If valid never appears, polling stops once TIMEOUT_US × CYC_PER_US cycles have passed since polling began, and the count register is read anyway. Its value is used as the result.
- R6: After the count is read, the configuration register is written with bit 24 clear (same length and channel), and then the monitor register is written with 0.
- R7: For a nonzero count C, the code is floor((floor(745472 / C) + 500) / 1000).
- R8: A count of zero gives code 4.
- R9: Any result above 7 is replaced by 7.
- R10: `slew_code` changes only while `osc_en` is high. `osc_en` falls on the next edge, and `done` is high for exactly that one cycle.
- R11: A start pulse while a calibration is in progress has no effect: no extra access, no change of channel, no extra done pulse.
- R12: A bus request holds `reg_we`, `reg_addr` and `reg_wdata` steady until `reg_ack`. A transfer happens in a cycle with both `reg_req` and `reg_ack` high, and read data is taken in that cycle.
- R13: After reset, `osc_en`, `done` and `reg_req` are low and `slew_code` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Calibration request pulse |
| port_sel | input | 2 | Meter channel for this port, captured at start |
| done | output | 1 | One-cycle pulse when the calibration has finished |
| osc_en | output | 1 | Ring oscillator enable |
| slew_code | output | 3 | Applied slew-rate code |
| reg_req | output | 1 | Bus request |
| reg_we | output | 1 | Bus write (1) or read (0) |
| reg_addr | output | 8 | Bus address |
| reg_wdata | output | 32 | Bus write data |
| reg_rdata | input | 32 | Bus read data, valid with reg_ack |
| reg_ack | input | 1 | Bus acknowledge, completes the pending request |

## Verification
The properties assume that the meter side acknowledges each request eventually, and only while a request is pending. They also assume that read data is valid in the acknowledge cycle and that reset is held for at least one edge before operation. The bench's meter model acknowledges every other cycle while a request is up. It returns the valid flag only after a chosen number of monitor reads, or never, and it presents the count combinationally from the address. Start pulses are single cycles, driven between edges, and some of them land deliberately inside a running calibration.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

    localparam int DW          = 32;
    localparam int AW          = 8;
    localparam int CODE_W      = 3;
    localparam int CHAN_W      = 2;

    // Meter configuration word layout, decoded by the meter.
    localparam int LEN_FIELD_W = 24;
    localparam int DET_EN_BIT  = 24;
    localparam int CHAN_LSB    = 26;

    // Meter monitor word layout.
    localparam int VALID_BIT   = 0;
    localparam int FRCK_BIT    = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FRCK_ON,
        ST_CFG,
        ST_DET_ON,
        ST_POLL,
        ST_POLL_GAP,
        ST_RD_VAL,
        ST_DET_OFF,
        ST_FRCK_OFF,
        ST_DIV_A,
        ST_DIV_B,
        ST_APPLY,
        ST_OSC_OFF
    } seq_state_t;

    typedef struct packed {
        logic          valid;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_cmd_t;

    function automatic logic [DW-1:0] meter_cfg(
        input logic [LEN_FIELD_W-1:0] len,
        input logic [CHAN_W-1:0]      chan,
        input logic                   det
    );
        logic [DW-1:0] w;
        w                       = '0;
        w[LEN_FIELD_W-1:0]      = len;
        w[DET_EN_BIT]           = det;
        w[CHAN_LSB +: CHAN_W]   = chan;
        return w;
    endfunction

    function automatic logic [CODE_W-1:0] clamp_code(input logic [DW-1:0] q);
        localparam logic [DW-1:0] CODE_MAX = DW'((1 << CODE_W) - 1);
        if (q > CODE_MAX) return CODE_W'((1 << CODE_W) - 1);
        return q[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/srcal_countdown.sv
module srcal_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/srcal_divider.sv
module srcal_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] left_q;
    logic          done_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                left_q <= CW'(W);
            end else if (left_q != '0) begin
                if (!trial[W]) begin
                    rem_q <= trial;
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;
endmodule

// File: rtl/srcal_bus_port.sv
module srcal_bus_port
    import srcal_pkg::*;
(
    input  bus_cmd_t      cmd,
    input  logic          reg_ack,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          xfer
);
    always_comb begin
        reg_req   = cmd.valid;
        reg_we    = cmd.valid & cmd.we;
        reg_addr  = cmd.valid ? cmd.addr : '0;
        reg_wdata = (cmd.valid && cmd.we) ? cmd.wdata : '0;
        xfer      = cmd.valid & reg_ack;
    end
endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
    import srcal_pkg::*;
#(
    parameter int            CYC_PER_US   = 200,
    parameter int            SETTLE_US    = 1,
    parameter int            POLL_US      = 10,
    parameter int            TIMEOUT_US   = 200,
    parameter int            METER_CYCLES = 1024,
    parameter int            REF_MHZ      = 26,
    parameter int            SR_COEF      = 28,
    parameter int            SR_DIV       = 1000,
    parameter int            DEFAULT_CODE = 4,
    parameter logic [7:0]    CFG_ADDR     = 8'h00,
    parameter logic [7:0]    VAL_ADDR     = 8'h0C,
    parameter logic [7:0]    MON_ADDR     = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CHAN_W-1:0] port_sel,
    output logic              done,
    output logic              osc_en,
    output logic [CODE_W-1:0] slew_code,
    output logic              reg_req,
    output logic              reg_we,
    output logic [AW-1:0]     reg_addr,
    output logic [DW-1:0]     reg_wdata,
    input  logic [DW-1:0]     reg_rdata,
    input  logic              reg_ack
);
    localparam int SETTLE_CYC  = SETTLE_US * CYC_PER_US;
    localparam int POLL_CYC    = POLL_US * CYC_PER_US;
    localparam int TIMEOUT_CYC = TIMEOUT_US * CYC_PER_US;
    localparam int WAIT_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
    localparam int WAIT_W      = $clog2(WAIT_MAX + 1);
    localparam int TMO_W       = $clog2(TIMEOUT_CYC + 1);

    localparam logic [DW-1:0]          CAL_NUM   = DW'(METER_CYCLES * REF_MHZ * SR_COEF);
    localparam logic [DW-1:0]          ROUND_ADD = DW'(SR_DIV / 2);
    localparam logic [DW-1:0]          SCALE_DIV = DW'(SR_DIV);
    localparam logic [LEN_FIELD_W-1:0] WIN_LEN   = LEN_FIELD_W'(METER_CYCLES);
    localparam logic [CODE_W-1:0]      DEF_CODE  = CODE_W'(DEFAULT_CODE);
    localparam logic [TMO_W-1:0]       TMO_LIM   = TMO_W'(TIMEOUT_CYC);
    localparam logic [DW-1:0]          FRCK_WORD = DW'(1) << FRCK_BIT;

    seq_state_t        state_q;
    logic [CHAN_W-1:0] chan_q;
    logic [DW-1:0]     count_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] slew_q;
    logic              osc_q;
    logic              done_q;
    logic [TMO_W-1:0]  elapsed_q;
    logic              timed_out;

    bus_cmd_t          cmd;
    logic              xfer;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_val;
    logic              wait_zero;
    logic              div_start;
    logic [DW-1:0]     div_num;
    logic [DW-1:0]     div_den;
    logic              div_done;
    logic [DW-1:0]     div_quo;

    assign timed_out = (elapsed_q == TMO_LIM);

    // Bus command, wait loads and divider launch, all decoded from the state.
    always_comb begin
        cmd       = '0;
        wait_load = 1'b0;
        wait_val  = '0;
        div_start = 1'b0;
        div_num   = CAL_NUM;
        div_den   = count_q;
        unique case (state_q)
            ST_IDLE: begin
                wait_load = start;
                wait_val  = WAIT_W'(SETTLE_CYC);
            end
            ST_FRCK_ON:  cmd = '{valid: 1'b1, we: 1'b1, addr: MON_ADDR, wdata: FRCK_WORD};
            ST_CFG:      cmd = '{valid: 1'b1, we: 1'b1, addr: CFG_ADDR,
                                 wdata: meter_cfg(WIN_LEN, chan_q, 1'b0)};
            ST_DET_ON:   cmd = '{valid: 1'b1, we: 1'b1, addr: CFG_ADDR,
                                 wdata: meter_cfg(WIN_LEN, chan_q, 1'b1)};
            ST_POLL: begin
                cmd       = '{valid: 1'b1, we: 1'b0, addr: MON_ADDR, wdata: '0};
                wait_load = xfer && !reg_rdata[VALID_BIT] && !timed_out;
                wait_val  = WAIT_W'(POLL_CYC);
            end
            ST_RD_VAL:   cmd = '{valid: 1'b1, we: 1'b0, addr: VAL_ADDR, wdata: '0};
            ST_DET_OFF:  cmd = '{valid: 1'b1, we: 1'b1, addr: CFG_ADDR,
                                 wdata: meter_cfg(WIN_LEN, chan_q, 1'b0)};
            ST_FRCK_OFF: begin
                cmd       = '{valid: 1'b1, we: 1'b1, addr: MON_ADDR, wdata: '0};
                div_start = xfer && (count_q != '0);
            end
            ST_DIV_A: begin
                div_start = div_done;
                div_num   = div_quo + ROUND_ADD;
                div_den   = SCALE_DIV;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            chan_q    <= '0;
            count_q   <= '0;
            code_q    <= DEF_CODE;
            slew_q    <= DEF_CODE;
            osc_q     <= 1'b0;
            done_q    <= 1'b0;
            elapsed_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    chan_q  <= port_sel;
                    osc_q   <= 1'b1;
                    state_q <= ST_SETTLE;
                end
                ST_SETTLE:  if (wait_zero) state_q <= ST_FRCK_ON;
                ST_FRCK_ON: if (xfer) state_q <= ST_CFG;
                ST_CFG:     if (xfer) state_q <= ST_DET_ON;
                ST_DET_ON: if (xfer) begin
                    elapsed_q <= '0;
                    state_q   <= ST_POLL;
                end
                ST_POLL: begin
                    if (!timed_out) elapsed_q <= elapsed_q + 1'b1;
                    if (xfer) begin
                        if (reg_rdata[VALID_BIT] || timed_out) state_q <= ST_RD_VAL;
                        else                                   state_q <= ST_POLL_GAP;
                    end
                end
                ST_POLL_GAP: begin
                    if (!timed_out) elapsed_q <= elapsed_q + 1'b1;
                    if (wait_zero) state_q <= ST_POLL;
                end
                ST_RD_VAL: if (xfer) begin
                    count_q <= reg_rdata;
                    state_q <= ST_DET_OFF;
                end
                ST_DET_OFF: if (xfer) state_q <= ST_FRCK_OFF;
                ST_FRCK_OFF: if (xfer) begin
                    if (count_q == '0) begin
                        code_q  <= DEF_CODE;
                        state_q <= ST_APPLY;
                    end else begin
                        state_q <= ST_DIV_A;
                    end
                end
                ST_DIV_A: if (div_done) state_q <= ST_DIV_B;
                ST_DIV_B: if (div_done) begin
                    code_q  <= clamp_code(div_quo);
                    state_q <= ST_APPLY;
                end
                ST_APPLY: begin
                    slew_q  <= code_q;
                    state_q <= ST_OSC_OFF;
                end
                ST_OSC_OFF: begin
                    osc_q   <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    srcal_countdown #(.W(WAIT_W)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .load  (wait_load),
        .value (wait_val),
        .zero  (wait_zero)
    );

    srcal_divider #(.W(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .done     (div_done),
        .quotient (div_quo)
    );

    srcal_bus_port u_bus (
        .cmd       (cmd),
        .reg_ack   (reg_ack),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .xfer      (xfer)
    );

    assign done      = done_q;
    assign osc_en    = osc_q;
    assign slew_code = slew_q;
endmodule

// File: rtl/srcal_seq_chk.sv
module srcal_seq_chk
    import srcal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              osc_en,
    input logic [CODE_W-1:0] slew_code,
    input logic              reg_req,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              reg_ack
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata));

    // R1
    settle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> !reg_req);

    // R1
    bus_needs_osc_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> osc_en);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_osc_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(osc_en));

    // R10
    code_window_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(slew_code) |-> osc_en);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req && start |=> osc_en);
endmodule

bind srcal_seq srcal_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .osc_en    (osc_en),
    .slew_code (slew_code),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack)
);

// File: tb/srcal_seq_test.sv
`timescale 1ns/1ps
module srcal_seq_test;
    import srcal_pkg::*;

    localparam int CPU     = 10;
    localparam int SETTLE  = 1 * CPU;
    localparam int POLL    = 10 * CPU;
    localparam int TMO     = 200 * CPU;
    localparam int NEVER   = 1000000;
    localparam logic [7:0] A_CFG = 8'h00;
    localparam logic [7:0] A_VAL = 8'h0C;
    localparam logic [7:0] A_MON = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  port_sel = 2'd0;
    logic        done, osc_en, reg_req, reg_we, reg_ack;
    logic [2:0]  slew_code;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    always #2.5 clk = ~clk;

    srcal_seq #(.CYC_PER_US(CPU)) uut (
        .clk(clk), .rst(rst), .start(start), .port_sel(port_sel),
        .done(done), .osc_en(osc_en), .slew_code(slew_code),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack)
    );

    typedef struct {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        bit          rep;
        string       tag;
    } item_t;

    item_t  exp_q[$];
    item_t  last_item;
    bit     have_last = 0;
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    int     mon_reads = 0;
    int     mon_base = 0;
    int     valid_after = 0;
    logic [31:0] meter_val = 0;
    longint poll_cyc[$];
    longint val_cyc = 0;
    longint first_cyc = 0;
    bit     got_first = 0;
    int     done_count = 0;
    int     extra_req = 0;

    // Meter model: acknowledges every other cycle while a request is up.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) reg_ack <= 1'b0;
        else     reg_ack <= reg_req && !reg_ack;
        if (reg_req && reg_ack && !reg_we && reg_addr == A_MON) mon_reads <= mon_reads + 1;
    end

    always_comb begin
        if (reg_addr == A_MON)      reg_rdata = {31'd0, ((mon_reads - mon_base) >= valid_after)};
        else if (reg_addr == A_VAL) reg_rdata = meter_val;
        else                        reg_rdata = 32'd0;
    end

    function automatic bit same(input item_t a, input item_t b);
        return a.we == b.we && a.addr == b.addr && (!a.we || a.wdata == b.wdata);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected bus items and compares them with each transfer.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_count++;
            if (reg_req && reg_ack) begin
                item_t g;
                g.we = reg_we; g.addr = reg_addr; g.wdata = reg_we ? reg_wdata : 32'd0;
                g.rep = 0; g.tag = "";
                if (!got_first) begin first_cyc = cyc; got_first = 1; end
                if (!reg_we && reg_addr == A_MON) poll_cyc.push_back(cyc);
                if (!reg_we && reg_addr == A_VAL) val_cyc = cyc;
                if (exp_q.size() > 0 && same(g, exp_q[0])) begin
                    last_item = exp_q.pop_front();
                    have_last = 1;
                    check(1, last_item.tag, 0, 0);
                end else if (have_last && last_item.rep && same(g, last_item)) begin
                    // another poll of the monitor register
                end else begin
                    extra_req++;
                    check(0, (exp_q.size() > 0) ? exp_q[0].tag : "R11 unexpected access",
                          {g.we, g.addr, g.wdata},
                          (exp_q.size() > 0) ? {exp_q[0].we, exp_q[0].addr, exp_q[0].wdata} : 0);
                end
            end
        end
    end

    function automatic int calc_code(input longint c);
        longint q;
        if (c == 0) return 4;
        q = (1024 * 26 * 28) / c;
        q = (q + 500) / 1000;
        return (q > 7) ? 7 : int'(q);
    endfunction

    function automatic item_t mk(input logic we, input logic [7:0] a, input logic [31:0] d,
                                 input bit rep, input string tag);
        item_t it;
        it.we = we; it.addr = a; it.wdata = d; it.rep = rep; it.tag = tag;
        return it;
    endfunction

    task automatic run_cal(input logic [1:0] ch, input logic [31:0] cnt, input int vafter,
                           input bit poke, input string code_tag);
        int     exp_code;
        int     w;
        longint osc_cyc;
        logic [31:0] base;
        exp_code = calc_code(cnt);
        base = 32'd1024 | (32'(ch) << 26);
        exp_q.push_back(mk(1, A_MON, 32'h100, 0, "R2 free-run enable"));
        exp_q.push_back(mk(1, A_CFG, base, 0, "R3 configure"));
        exp_q.push_back(mk(1, A_CFG, base | 32'h0100_0000, 0, "R3 detect enable"));
        exp_q.push_back(mk(0, A_MON, 0, 1, "R4 poll"));
        exp_q.push_back(mk(0, A_VAL, 0, 0, "R4 count read"));
        exp_q.push_back(mk(1, A_CFG, base, 0, "R6 detect disable"));
        exp_q.push_back(mk(1, A_MON, 0, 0, "R6 free-run disable"));
        meter_val = cnt; valid_after = vafter; mon_base = mon_reads;
        poll_cyc.delete(); got_first = 0; done_count = 0; extra_req = 0; have_last = 0;
        @(negedge clk); port_sel = ch; start = 1'b1;
        @(negedge clk); start = 1'b0; osc_cyc = cyc;
        check(osc_en === 1'b1, "R1 osc_en after start", osc_en, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            port_sel = ~ch; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (30) @(negedge clk);
            port_sel = ~ch; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        check(w < 20000, "watchdog expired", w, 20000);
        check(first_cyc - osc_cyc >= SETTLE && first_cyc - osc_cyc <= SETTLE + 4,
              "R1 settle gap", first_cyc - osc_cyc, SETTLE);
        check(slew_code == 3'(exp_code), code_tag, slew_code, exp_code);
        check(osc_en == 1'b0, "R10 osc_en low with done", osc_en, 0);
        check(exp_q.size() == 0, "R6 sequence complete", exp_q.size(), 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        repeat (20) @(negedge clk);
        check(done_count == 1 && extra_req == 0, "R11 single completion",
              done_count + extra_req, 1);
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(osc_en == 0, "R13 osc_en reset", osc_en, 0);
        check(done == 0, "R13 done reset", done, 0);
        check(reg_req == 0, "R13 req reset", reg_req, 0);
        check(slew_code == 3'd4, "R13 code reset", slew_code, 4);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        run_cal(2'd0, 32'd186, 0, 0, "R7 code count 186");
        run_cal(2'd1, 32'd240, 2, 0, "R7 code count 240");
        check(poll_cyc.size() == 3, "R4 poll count", poll_cyc.size(), 3);
        for (int i = 1; i < poll_cyc.size(); i++)
            check(poll_cyc[i] - poll_cyc[i-1] >= POLL && poll_cyc[i] - poll_cyc[i-1] <= POLL + 4,
                  "R4 poll interval", poll_cyc[i] - poll_cyc[i-1], POLL);
        run_cal(2'd2, 32'd0, 0, 0, "R8 zero count default");
        run_cal(2'd3, 32'd50, 0, 0, "R9 clamp count 50");
        run_cal(2'd1, 32'd2000, 0, 1, "R11 code with ignored starts");
        run_cal(2'd2, 32'd240, NEVER, 0, "R5 code after timeout");
        check(val_cyc - poll_cyc[0] >= TMO - 2 && val_cyc - poll_cyc[0] <= TMO + POLL + 8,
              "R5 timeout window", val_cyc - poll_cyc[0], TMO);
        run_cal(2'd0, 32'd1, 1, 0, "R9 clamp count 1");
        run_cal(2'd3, 32'd149, 1, 0, "R7 code count 149");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule